// File: doc/BRIEF.md
# Transmit Driver Fault Supervisor

This block watches over the transmit path of a single-wire, open-collector bus driver. It gathers five independent fault sources into one flag for the driver's mode controller. The sources are a transmit-dominant timeout, a bus-dominant timeout, a transmit/receive comparison for contention and supply shorts, a receive-line monitor, and a thermal-shutdown flag from an analog sensor. While any source is active, the block forces the driver input recessive. It also drives an active-low fault report that a host can read.

All six inputs are asynchronous and pass through a synchronizer chain of `SYNC_STAGES` flops before use. Time limits are given as clock-cycle parameters. The comparison between transmit and receive data is not continuous. It is sampled `SAMPLE_DLY` cycles after each transmit transition, which lets bus propagation delay settle, and the result is held until the next sample point. Each source has its own status bit and its own clear condition.

Top module: `drv_fault_supervisor`

## Requirements
- R1: During and after reset, `fault_o`=0, `fault_n_o`=1, `drv_txd_o`=1 and `status_o`=0.
- R2: The transmit-timeout source (status bit 0) sets only after transmit data has been low for more than `TXD_LIMIT` consecutive synchronized cycles. A low run of `TXD_LIMIT` cycles or fewer never sets it.
- R3: The transmit-timeout source clears on the next rising edge of synchronized transmit data.
- R4: The bus-timeout source (status bit 1) sets only after the bus level input has been 0 (dominant) for more than `BUS_LIMIT` consecutive cycles. Any recessive cycle restarts the count.
- R5: The bus-timeout source clears only in a cycle with the bus recessive and chip-select high. With chip-select low it stays set.
- R6: Comparison is evaluated `SAMPLE_DLY` cycles after each synchronized transmit transition. With the transmitter active, status bit 3 (short) is set when transmit is 0 and receive is 1, and status bit 2 (contention) is set when transmit is 1 and receive is 0. With the transmitter inactive at the sample, both bits clear.
- R7: Bits 2 and 3 keep their value between sample points, whatever receive data does.
- R8: Status bit 4 is set while the bus is recessive (1) and receive data is 0, and is clear otherwise.
- R9: Status bit 5 follows the thermal flag and clears by itself when the flag drops.
- R10: `fault_o` is the OR of all six status bits.
- R11: `fault_n_o` is the inverse of `fault_o` delayed by one cycle.
- R12: `drv_txd_o` is 1 in the cycle after `fault_o` was 1. Otherwise it carries the synchronized transmit data.
- R13: Inputs reach the status bits after exactly `SYNC_STAGES`+1 clock edges: a thermal change first shows at `fault_o` three edges after it is sampled, with the default of two stages. Timeout counters saturate and never wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txd_i | input | 1 | Transmit data from the controller (0 = dominant) |
| rxd_i | input | 1 | Receive data from the bus comparator |
| bus_rec_i | input | 1 | Digitized bus level, 1 = recessive |
| therm_i | input | 1 | Thermal-shutdown flag from the analog sensor |
| cs_i | input | 1 | Chip-select |
| tx_act_i | input | 1 | Transmitter-active indication from the mode controller |
| fault_o | output | 1 | Combined fault flag to the mode controller |
| fault_n_o | output | 1 | Active-low registered fault report |
| drv_txd_o | output | 1 | Transmit data to the driver, forced 1 on fault |
| status_o | output | 6 | Per-source status: 0 tx timeout, 1 bus timeout, 2 contention, 3 short, 4 receive monitor, 5 thermal |

## Verification
The hardest behaviour to reach from the ports is the hold of the comparison result between sample points. Receive data must change while transmit data stays still, and the bench must look just before the next strobe. The stimulus first parks the flags in a known state. It then changes receive and transmit data together, reads the old value one cycle before the sample point, and reads the new value after it. The timeout boundaries are reached by sweeping dominant pulse lengths from one cycle to just past each limit, with the expected outcome computed from the pulse length alone.

// File: rtl/drvflt_pkg.sv
package drvflt_pkg;

  localparam int SRC_N     = 6;
  localparam int IDX_TXTMO = 0;
  localparam int IDX_BUSTO = 1;
  localparam int IDX_CONT  = 2;
  localparam int IDX_SHORT = 3;
  localparam int IDX_RXMON = 4;
  localparam int IDX_THERM = 5;

  typedef struct packed {
    logic short_f;
    logic cont_f;
  } cmp_t;

  // saturating run-length counter step
  function automatic int next_count(int cur, int lim, logic run);
    if (!run) return 0;
    if (cur >= lim) return lim;
    return cur + 1;
  endfunction

  // transmit/receive comparison at a sample point
  function automatic cmp_t eval_cmp(logic act, logic txd, logic rxd);
    cmp_t r;
    r.short_f = act & ~txd & rxd;
    r.cont_f  = act & txd & ~rxd;
    return r;
  endfunction

  // receive line must read high while the bus is recessive
  function automatic logic rxmon_bad(logic bus_rec, logic rxd);
    return bus_rec & ~rxd;
  endfunction

endpackage

// File: rtl/drvflt_sync.sv
module drvflt_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= RST_VAL;
        else        stg_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= RST_VAL;
        else        stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/drvflt_dom_timer.sv
module drvflt_dom_timer
  import drvflt_pkg::*;
#(
  parameter int LIMIT = 25000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dom_i,
  input  logic clr_i,
  output logic flag_o
);

  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;
  logic          flag_q;
  logic          hit_w;

  assign hit_w = dom_i && (int'(cnt_q) == LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= CW'(next_count(int'(cnt_q), LIMIT, dom_i));
      flag_q <= clr_i ? 1'b0 : (flag_q | hit_w);
    end
  end

  assign flag_o = flag_q;

  // R13
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= LIMIT);

  // R2
  flag_set_dom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_o) |-> $past(dom_i));

  // R5
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !flag_o);

endmodule

// File: rtl/drvflt_cmp.sv
module drvflt_cmp
  import drvflt_pkg::*;
#(
  parameter int DLY = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic txd_i,
  input  logic rxd_i,
  input  logic act_i,
  output cmp_t flags_o
);

  localparam int DW = $clog2(DLY + 1);

  logic          txd_prev_q;
  logic [DW-1:0] dcnt_q;
  logic          edge_w;
  logic          strobe_w;
  cmp_t          flags_q;

  assign edge_w   = txd_i ^ txd_prev_q;
  assign strobe_w = (dcnt_q == DW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txd_prev_q <= 1'b1;
      dcnt_q     <= '0;
      flags_q    <= '0;
    end else begin
      txd_prev_q <= txd_i;
      if (edge_w)              dcnt_q <= DW'(DLY);
      else if (dcnt_q != '0)   dcnt_q <= dcnt_q - 1'b1;
      if (strobe_w)            flags_q <= eval_cmp(act_i, txd_i, rxd_i);
    end
  end

  assign flags_o = flags_q;

  // R7
  cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(flags_o) |-> $past(strobe_w));

  // R6
  cmp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(flags_o.short_f && flags_o.cont_f));

endmodule

// File: rtl/drv_fault_supervisor.sv
module drv_fault_supervisor
  import drvflt_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int TXD_LIMIT   = 25000,
  parameter int BUS_LIMIT   = 25000,
  parameter int SAMPLE_DLY  = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             txd_i,
  input  logic             rxd_i,
  input  logic             bus_rec_i,
  input  logic             therm_i,
  input  logic             cs_i,
  input  logic             tx_act_i,
  output logic             fault_o,
  output logic             fault_n_o,
  output logic             drv_txd_o,
  output logic [SRC_N-1:0] status_o
);

  localparam int          NIN     = 6;
  localparam logic [NIN-1:0] IN_RST = 6'b000111;

  logic [NIN-1:0] raw_w, syn_w;
  logic s_txd, s_rxd, s_bus, s_therm, s_cs, s_act;

  assign raw_w = {tx_act_i, cs_i, therm_i, bus_rec_i, rxd_i, txd_i};

  drvflt_sync #(.W(NIN), .STAGES(SYNC_STAGES), .RST_VAL(IN_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw_w), .q_o(syn_w)
  );

  assign {s_act, s_cs, s_therm, s_bus, s_rxd, s_txd} = syn_w;

  // transmit rising edge releases the transmit timeout
  logic txd_last_q;
  logic txd_rise_w;
  assign txd_rise_w = s_txd & ~txd_last_q;

  logic txtmo_w, bustmo_w;

  drvflt_dom_timer #(.LIMIT(TXD_LIMIT)) u_tx_tmr (
    .clk(clk), .rst_n(rst_n), .dom_i(~s_txd), .clr_i(txd_rise_w), .flag_o(txtmo_w)
  );

  drvflt_dom_timer #(.LIMIT(BUS_LIMIT)) u_bus_tmr (
    .clk(clk), .rst_n(rst_n), .dom_i(~s_bus), .clr_i(s_bus & s_cs), .flag_o(bustmo_w)
  );

  cmp_t cmp_w;

  drvflt_cmp #(.DLY(SAMPLE_DLY)) u_cmp (
    .clk(clk), .rst_n(rst_n), .txd_i(s_txd), .rxd_i(s_rxd), .act_i(s_act), .flags_o(cmp_w)
  );

  logic rxmon_q, therm_q, rpt_n_q, drv_q;
  logic [SRC_N-1:0] status_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txd_last_q <= 1'b1;
      rxmon_q    <= 1'b0;
      therm_q    <= 1'b0;
    end else begin
      txd_last_q <= s_txd;
      rxmon_q    <= rxmon_bad(s_bus, s_rxd);
      therm_q    <= s_therm;
    end
  end

  always_comb begin
    status_w            = '0;
    status_w[IDX_TXTMO] = txtmo_w;
    status_w[IDX_BUSTO] = bustmo_w;
    status_w[IDX_CONT]  = cmp_w.cont_f;
    status_w[IDX_SHORT] = cmp_w.short_f;
    status_w[IDX_RXMON] = rxmon_q;
    status_w[IDX_THERM] = therm_q;
  end

  assign fault_o  = |status_w;
  assign status_o = status_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rpt_n_q <= 1'b1;
      drv_q   <= 1'b1;
    end else begin
      rpt_n_q <= ~fault_o;
      drv_q   <= fault_o ? 1'b1 : s_txd;
    end
  end

  assign fault_n_o = rpt_n_q;
  assign drv_txd_o = drv_q;

  // R11
  rpt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (fault_n_o == !$past(fault_o)));

  // R12
  drv_recessive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |=> drv_txd_o);

  // R9
  therm_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !s_therm |=> !status_o[IDX_THERM]);

  // R8
  rxmon_dom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !s_bus |=> !status_o[IDX_RXMON]);

endmodule

// File: tb/drv_fault_supervisor_tb.sv
module drv_fault_supervisor_tb;

  localparam int TL  = 40;
  localparam int BL  = 30;
  localparam int DLY = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic txd = 1'b1, rxd = 1'b1, bus = 1'b1, therm = 1'b0, cs = 1'b0, tx_act = 1'b0;
  logic fault, fault_n, drv;
  logic [5:0] st;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  drv_fault_supervisor #(
    .SYNC_STAGES(2), .TXD_LIMIT(TL), .BUS_LIMIT(BL), .SAMPLE_DLY(DLY)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .txd_i(txd), .rxd_i(rxd), .bus_rec_i(bus),
    .therm_i(therm), .cs_i(cs), .tx_act_i(tx_act),
    .fault_o(fault), .fault_n_o(fault_n), .drv_txd_o(drv), .status_o(st)
  );

  task automatic chk(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic watch(int n, inout bit seen);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (fault) seen = 1'b1;
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit seen;
    // R1 reset state
    cyc(3);
    chk("R1 fault", fault, 0);
    chk("R1 fault_n", fault_n, 1);
    chk("R1 drv", drv, 1);
    chk("R1 status", st, 0);
    rst_n = 1'b1;
    cs = 1'b1;
    cyc(5);
    chk("R1 idle", st, 0);

    // R2/R3 transmit-low sweep
    for (int len = 1; len <= TL + 3; len++) begin
      seen = 1'b0;
      txd = 1'b0;
      watch(len, seen);
      txd = 1'b1;
      watch(8, seen);
      chk("R2 tx timeout by length", int'(seen), int'(len > TL));
      chk("R3 tx timeout released", fault, 0);
    end
    txd = 1'b0;
    cyc(TL + 8);
    chk("R2 tx timeout bit0", st[0], 1);
    chk("R12 drv forced", drv, 1);
    chk("R11 report low", fault_n, 0);
    txd = 1'b1;
    cyc(6);
    chk("R3 cleared on rise", st[0], 0);

    // R4 bus-dominant sweep
    for (int len = 1; len <= BL + 3; len++) begin
      seen = 1'b0;
      bus = 1'b0;
      watch(len, seen);
      bus = 1'b1;
      watch(8, seen);
      chk("R4 bus timeout by length", int'(seen), int'(len > BL));
      chk("R4 bus timeout released", fault, 0);
    end
    seen = 1'b0;
    bus = 1'b0; watch(BL - 5, seen);
    bus = 1'b1; watch(1, seen);
    bus = 1'b0; watch(BL - 5, seen);
    bus = 1'b1; watch(8, seen);
    chk("R4 recessive restarts count", int'(seen), 0);

    // R5 clear needs chip-select
    cs = 1'b0;
    bus = 1'b0;
    cyc(BL + 10);
    bus = 1'b1;
    cyc(10);
    chk("R5 held with cs low", st[1], 1);
    cs = 1'b1;
    cyc(6);
    chk("R5 cleared with cs high", st[1], 0);

    // R6/R7 comparison sweep
    tx_act = 1'b1;
    for (int t = 0; t < 2; t++) begin
      for (int r = 0; r < 2; r++) begin
        txd = 1'b1; rxd = 1'b1;
        cyc(DLY + 8);
        txd = logic'(1 - t);
        cyc(DLY + 8);
        chk("R6 prior short", st[3], t);
        chk("R6 prior cont", st[2], 0);
        rxd = logic'(r);
        txd = logic'(t);
        cyc(DLY + 1);
        chk("R7 short held", st[3], t);
        chk("R7 cont held", st[2], 0);
        cyc(6);
        chk("R6 short sampled", st[3], int'(t == 0 && r == 1));
        chk("R6 cont sampled", st[2], int'(t == 1 && r == 0));
      end
    end
    txd = 1'b1; rxd = 1'b1;
    cyc(DLY + 8);
    txd = 1'b0;
    cyc(DLY + 8);
    chk("R6 short before idle", st[3], 1);
    tx_act = 1'b0;
    txd = 1'b1;
    cyc(DLY + 8);
    chk("R6 inactive clears short", st[3], 0);
    chk("R6 inactive clears cont", st[2], 0);

    // R8 receive monitor
    rxd = 1'b0;
    cyc(6);
    chk("R8 rx low while recessive", st[4], 1);
    bus = 1'b0;
    cyc(6);
    chk("R8 rx low while dominant", st[4], 0);
    bus = 1'b1; rxd = 1'b1;
    cyc(6);
    chk("R8 rx high", st[4], 0);
    chk("R10 all clear", fault, 0);

    // R13/R9/R11 thermal latency
    therm = 1'b1;
    cyc(2);
    chk("R13 not yet through sync", fault, 0);
    cyc(1);
    chk("R13 thermal arrives", fault, 1);
    chk("R9 thermal bit", st[5], 1);
    chk("R11 report lags", fault_n, 1);
    cyc(1);
    chk("R11 report low", fault_n, 0);
    txd = 1'b0;
    cyc(6);
    chk("R12 drv recessive on thermal", drv, 1);
    rxd = 1'b0;
    cyc(6);
    chk("R10 OR of sources", st, 6'b110000);
    rxd = 1'b1; txd = 1'b1; therm = 1'b0;
    cyc(6);
    chk("R9 thermal self-clears", st, 0);
    chk("R11 report released", fault_n, 1);
    txd = 1'b0;
    cyc(5);
    chk("R12 drv follows txd", drv, 0);
    txd = 1'b1;
    cyc(5);
    chk("R12 drv follows txd high", drv, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule